// File: doc/BRIEF.md
# Validated Configuration Byte Store

This block holds the byte-wide configuration values of a locomotive decoder: the short and long addresses, motor start voltage, rate values, PWM period, timeout, the consist group and the configuration flags byte. Writes reach it as single-cycle requests. Each request carries a register number, a data byte and a flag that marks whether it came over the running track (operations mode) or from a programming track (service mode). Before a write is committed, it is checked against a per-register legality rule and against what it changes in other registers. One cycle after each request, the block returns an accept flag, which the surrounding logic can use to start an acknowledge.

Two registers act together as a 14-bit long address. The high byte is held in a staging latch until the matching low byte arrives. A small state machine tracks the pair. It has two states: `PR_IDLE`, where nothing is staged, and `PR_ARMED`, where a legal high byte waits for its low byte. An accepted high-byte write moves it from `PR_IDLE` to `PR_ARMED`, or keeps it in `PR_ARMED` with the new byte staged. Any other request moves it back to `PR_IDLE`, and that includes the low-byte write that commits the pair. A combinational read port returns the stored value of any register number.

Top module: `cfg_store`

## Requirements
- R1: After reset, reads return these values by register number: 1 gives 3, 2 gives 7, 9 gives 180, 17 gives 0xC0, 18 gives 0x00, 8 gives 141, 7 gives the VERSION parameter, and 3, 4, 11, 19, 21, 22, 23, 24 and 29 give 0.
- R2: Every cycle with `req_valid` high is followed by exactly one cycle with `rsp_valid` high, which carries the accept decision in `rsp_accept`. A cycle without a request is followed by `rsp_valid` low.
- R3: A service-mode write to register 1 is accepted only for data 1 to 127. When it is accepted, register 19 becomes 0 and bit 5 of register 29 becomes 0, and the other bits of register 29 keep their values.
- R4: An operations-mode write to register 1 is rejected. Register 7 rejects every write in both modes and always reads VERSION.
- R5: A write to register 17 is legal only for data 0xC0 to 0xE7. A write to register 18 takes any data. Both bytes become visible together when the low byte is accepted, and a staged high byte does not change what register 17 reads.
- R6: A write to register 18 is accepted only when the request just before it was an accepted write to register 17. Idle cycles between the two do not cancel the pair, but any other request in between does, whether accepted or rejected.
- R7: In operations mode, writes to registers 17 and 18 are rejected while bit 5 of register 29 is set.
- R8: A write to register 9 is rejected for data above 230. Data of 230 or below is accepted.
- R9: Writing 8 to register 8 is accepted and returns every register to its R1 value. Any other write to register 8 is rejected and leaves register 8 reading 141.
- R10: A request to any register number other than 1, 2, 3, 4, 7, 8, 9, 11, 17, 18, 19, 21, 22, 23, 24 and 29 is rejected and changes no stored value. Such a number reads as 0.
- R11: Writes to registers 2, 3, 4, 11, 19, 21, 22, 23, 24 and 29 are accepted with any data in either mode, and the register then reads back that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request strobe, one cycle per request |
| req_ops | input | 1 | 1 = operations mode, 0 = service mode |
| req_index | input | IDX_W | Register number |
| req_data | input | 8 | Data byte to write |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_accept | output | 1 | 1 = write was legal and committed |
| rd_index | input | IDX_W | Register number to read |
| rd_data | output | 8 | Stored value of `rd_index`, combinational |

## Verification
If the pair state machine is stuck in `PR_ARMED`, a low-byte write after an unrelated request is accepted when it should not be. That shows up on `rsp_accept` one cycle after the offending request. A bad commit, such as a restore that skips a register or a primary write that does not clear register 19, is visible on `rd_data` as soon as the response cycle arrives. The bench reads back every register number at regular intervals, so such corruption is seen within a few dozen requests. Rejected writes must leave the store bit-for-bit unchanged in the response cycle.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

    typedef enum logic [4:0] {
        SL_PRI, SL_VST, SL_ACC, SL_BRK, SL_VER, SL_MFG, SL_PWM, SL_TMO,
        SL_EXH, SL_EXL, SL_CON, SL_CFA, SL_CFL, SL_CAC, SL_CBR, SL_CFG,
        SL_NONE
    } slot_e;

    localparam int NSLOT = 16;
    localparam logic [7:0] MFG_CODE  = 8'd141;
    localparam logic [7:0] RESTORE_K = 8'd8;
    localparam logic [7:0] PWM_LIMIT = 8'd230;
    localparam logic [7:0] HI_MIN    = 8'hC0;
    localparam logic [7:0] HI_MAX    = 8'hE7;
    localparam logic [7:0] PRI_MAX   = 8'd127;
    localparam int         LONG_BIT  = 5;

    function automatic slot_e idx2slot(input logic [31:0] i);
        case (i)
            32'd1:   return SL_PRI;
            32'd2:   return SL_VST;
            32'd3:   return SL_ACC;
            32'd4:   return SL_BRK;
            32'd7:   return SL_VER;
            32'd8:   return SL_MFG;
            32'd9:   return SL_PWM;
            32'd11:  return SL_TMO;
            32'd17:  return SL_EXH;
            32'd18:  return SL_EXL;
            32'd19:  return SL_CON;
            32'd21:  return SL_CFA;
            32'd22:  return SL_CFL;
            32'd23:  return SL_CAC;
            32'd24:  return SL_CBR;
            32'd29:  return SL_CFG;
            default: return SL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] slot_dflt(input slot_e s, input logic [7:0] ver);
        case (s)
            SL_PRI:  return 8'd3;
            SL_VST:  return 8'd7;
            SL_PWM:  return 8'd180;
            SL_EXH:  return 8'hC0;
            SL_VER:  return ver;
            SL_MFG:  return MFG_CODE;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfgs_check.sv
module cfgs_check
    import cfgs_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             req_ops,
    input  logic [IDX_W-1:0] req_index,
    input  logic [7:0]       req_data,
    input  logic             long_en,
    input  logic             pend,
    output slot_e            slot,
    output logic             legal,
    output logic             is_hi,
    output logic             is_lo,
    output logic             is_restore,
    output logic             is_pri
);
    logic pair_locked;

    always_comb begin
        slot        = idx2slot(32'(req_index));
        pair_locked = req_ops && long_en;
        legal       = 1'b0;
        is_hi       = 1'b0;
        is_lo       = 1'b0;
        is_restore  = 1'b0;
        is_pri      = 1'b0;
        unique case (slot)
            SL_PRI: begin
                legal  = !req_ops && (req_data != 8'd0) && (req_data <= PRI_MAX);
                is_pri = legal;
            end
            SL_VER:  legal = 1'b0;
            SL_MFG: begin
                is_restore = (req_data == RESTORE_K);
                legal      = is_restore;
            end
            SL_PWM:  legal = (req_data <= PWM_LIMIT);
            SL_EXH: begin
                legal = !pair_locked && (req_data >= HI_MIN) && (req_data <= HI_MAX);
                is_hi = legal;
            end
            SL_EXL: begin
                legal = !pair_locked && pend;
                is_lo = legal;
            end
            SL_NONE: legal = 1'b0;
            default: legal = 1'b1;
        endcase
    end
endmodule

// File: rtl/cfgs_pair.sv
module cfgs_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       hi_ok,
    input  logic [7:0] hi_data,
    output logic       pend,
    output logic [7:0] stage
);
    typedef enum logic {PR_IDLE, PR_ARMED} pr_state_e;
    pr_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PR_IDLE:  if (req_valid && hi_ok) st_d = PR_ARMED;
            PR_ARMED: if (req_valid && !hi_ok) st_d = PR_IDLE;
            default:  st_d = PR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 stage <= 8'd0;
        else if (req_valid && hi_ok) stage <= hi_data;
    end

    assign pend = (st_q == PR_ARMED);
endmodule

// File: rtl/cfgs_bank.sv
module cfgs_bank
    import cfgs_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'd1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  slot_e                 slot,
    input  logic [7:0]            data,
    input  logic                  pair_we,
    input  logic [7:0]            hi_byte,
    input  logic                  pri_side,
    input  logic                  restore,
    output logic [NSLOT-1:0][7:0] store_q
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam slot_e ME = slot_e'(g);
        localparam logic [7:0] DFLT = slot_dflt(ME, VERSION);
        always_ff @(posedge clk) begin
            if (!rst_n || restore)                   store_q[g] <= DFLT;
            else if (pair_we && ME == SL_EXH)        store_q[g] <= hi_byte;
            else if (pair_we && ME == SL_EXL)        store_q[g] <= data;
            else if (we && slot == ME)               store_q[g] <= data;
            else if (pri_side && ME == SL_CON)       store_q[g] <= 8'd0;
            else if (pri_side && ME == SL_CFG)       store_q[g][LONG_BIT] <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfgs_pkg::*;
#(
    parameter int         IDX_W   = 10,
    parameter logic [7:0] VERSION = 8'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_ops,
    input  logic [IDX_W-1:0] req_index,
    input  logic [7:0]       req_data,
    output logic             rsp_valid,
    output logic             rsp_accept,
    input  logic [IDX_W-1:0] rd_index,
    output logic [7:0]       rd_data
);
    slot_e                 slot, rd_slot;
    logic                  legal, is_hi, is_lo, is_restore, is_pri;
    logic                  pend, hit;
    logic [7:0]            stage;
    logic [NSLOT-1:0][7:0] store_q;

    cfgs_check #(.IDX_W(IDX_W)) u_check (
        .req_ops    (req_ops),
        .req_index  (req_index),
        .req_data   (req_data),
        .long_en    (store_q[SL_CFG][LONG_BIT]),
        .pend       (pend),
        .slot       (slot),
        .legal      (legal),
        .is_hi      (is_hi),
        .is_lo      (is_lo),
        .is_restore (is_restore),
        .is_pri     (is_pri)
    );

    cfgs_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hi_ok     (is_hi),
        .hi_data   (req_data),
        .pend      (pend),
        .stage     (stage)
    );

    assign hit = req_valid && legal;

    cfgs_bank #(.VERSION(VERSION)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (hit && !is_hi && !is_lo && !is_restore),
        .slot     (slot),
        .data     (req_data),
        .pair_we  (hit && is_lo),
        .hi_byte  (stage),
        .pri_side (hit && is_pri),
        .restore  (hit && is_restore),
        .store_q  (store_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_accept <= hit;
        end
    end

    always_comb begin
        rd_slot = idx2slot(32'(rd_index));
        rd_data = (rd_slot == SL_NONE) ? 8'd0 : store_q[rd_slot[3:0]];
    end
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk
    import cfgs_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'd1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  rsp_valid,
    input logic                  rsp_accept,
    input logic [NSLOT-1:0][7:0] store_q
);
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);  // R2
    AST_PRI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        store_q[SL_PRI] != 8'd0 && store_q[SL_PRI] <= PRI_MAX);  // R3
    AST_VER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        store_q[SL_VER] == VERSION);  // R4
    AST_HI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        store_q[SL_EXH] >= HI_MIN && store_q[SL_EXH] <= HI_MAX);  // R5
    AST_PWM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        store_q[SL_PWM] <= PWM_LIMIT);  // R8
    AST_REJECT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_accept) |-> $stable(store_q));  // R10
endmodule

bind cfg_store cfg_store_chk #(.VERSION(VERSION)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_accept (rsp_accept),
    .store_q    (store_q)
);

// File: tb/tb_cfg_store.sv
`timescale 1ns/1ps
module tb_cfg_store;
    localparam int IDX_W = 10;
    localparam logic [7:0] VER = 8'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ops = 1'b0;
    logic [IDX_W-1:0] req_index = '0, rd_index = '0;
    logic [7:0] req_data = '0;
    logic rsp_valid, rsp_accept;
    logic [7:0] rd_data;

    int checks = 0, errors = 0;
    logic [7:0] m [0:31];
    logic m_pend = 1'b0;
    logic [7:0] m_stage = 8'd0;

    always #2 clk = ~clk;

    cfg_store #(.IDX_W(IDX_W), .VERSION(VER)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ops(req_ops),
        .req_index(req_index), .req_data(req_data), .rsp_valid(rsp_valid),
        .rsp_accept(rsp_accept), .rd_index(rd_index), .rd_data(rd_data));

    function automatic bit known(input int i);
        case (i)
            1, 2, 3, 4, 7, 8, 9, 11, 17, 18, 19, 21, 22, 23, 24, 29: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] dflt(input int i);
        case (i)
            1: return 8'd3;   2: return 8'd7;   7: return VER;  8: return 8'd141;
            9: return 8'd180; 17: return 8'hC0;
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag(input int i);
        case (i)
            1: return "R3"; 7: return "R4"; 8: return "R9"; 9: return "R8";
            17, 18: return "R5";
            default: return known(i) ? "R11" : "R10";
        endcase
    endfunction

    task automatic check(input string r, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < 32; i++) m[i] = known(i) ? dflt(i) : 8'd0;
    endtask

    task automatic mdl_write(input bit ops, input int i, input logic [7:0] d, output bit acc);
        bit locked = ops && m[29][5];
        bit nxt = 1'b0;
        acc = 1'b0;
        case (i)
            1: begin
                acc = !ops && d >= 1 && d <= 127;
                if (acc) begin m[1] = d; m[19] = 8'd0; m[29][5] = 1'b0; end
            end
            7: acc = 1'b0;
            8: begin acc = (d == 8'd8); if (acc) mdl_reset(); end
            9: begin acc = (d <= 8'd230); if (acc) m[9] = d; end
            17: begin
                acc = !locked && d >= 8'hC0 && d <= 8'hE7;
                if (acc) begin m_stage = d; nxt = 1'b1; end
            end
            18: begin
                acc = !locked && m_pend;
                if (acc) begin m[17] = m_stage; m[18] = d; end
            end
            default: begin
                acc = known(i);
                if (acc) m[i] = d;
            end
        endcase
        m_pend = nxt;
    endtask

    task automatic do_req(input bit ops, input int i, input logic [7:0] d, input string note);
        bit acc;
        @(negedge clk);
        req_valid = 1'b1; req_ops = ops; req_index = IDX_W'(i); req_data = d;
        mdl_write(ops, i, d, acc);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", int'(rsp_valid), 1, "rsp_valid after request");
        check(tag(i), int'(rsp_accept), int'(acc), $sformatf("accept idx=%0d data=%0d ops=%0d %s", i, d, ops, note));
        @(negedge clk);
        check("R2", int'(rsp_valid), 0, "rsp_valid idle");
    endtask

    task automatic sweep(input string r);
        for (int i = 0; i < 32; i++) begin
            rd_index = IDX_W'(i);
            #0.1;
            check(known(i) ? r : "R10", int'(rd_data), int'(m[i]), $sformatf("readback idx=%0d", i));
        end
        rd_index = IDX_W'(300);
        #0.1;
        check("R10", int'(rd_data), 0, "readback idx=300");
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finished");
        summary();
    end

    initial begin
        int idxs [0:22] = '{1, 2, 3, 4, 7, 8, 9, 11, 17, 18, 19, 21, 22, 23, 24, 29,
                            0, 5, 6, 10, 12, 30, 200};
        logic [7:0] corners [0:9] = '{8'd0, 8'd1, 8'd8, 8'd127, 8'd128, 8'd230,
                                      8'd231, 8'hBF, 8'hC0, 8'hE7};
        void'($urandom(32'd20240611));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", int'(rsp_valid), 0, "rsp_valid after reset");
        sweep("R1");

        do_req(0, 19, 8'h85, "consist set R11");
        do_req(0, 29, 8'h26, "flags with long bit R11");
        do_req(0, 1, 8'd0, "primary zero R3");
        do_req(0, 1, 8'd128, "primary 128 R3");
        do_req(0, 1, 8'd127, "primary max R3");
        sweep("R3");
        do_req(1, 1, 8'd5, "ops primary R4");
        do_req(0, 7, 8'd9, "version write R4");
        do_req(0, 17, 8'hBF, "hi below R5");
        do_req(0, 17, 8'hE8, "hi above R5");
        do_req(0, 17, 8'hDB, "hi ok R5");
        rd_index = IDX_W'(17); #0.1;
        check("R5", int'(rd_data), 8'hC0, "staged hi not visible");
        repeat (3) @(negedge clk);
        do_req(0, 18, 8'hF0, "lo after idle R6");
        sweep("R5");
        do_req(0, 18, 8'h11, "lo without hi R6");
        do_req(0, 17, 8'hC4, "hi R6");
        do_req(0, 5, 8'h00, "unsupported between R6");
        do_req(0, 18, 8'h22, "lo cancelled R6");
        do_req(0, 29, 8'h20, "long enable R11");
        do_req(1, 17, 8'hC1, "ops hi locked R7");
        do_req(1, 18, 8'h33, "ops lo locked R7");
        do_req(0, 17, 8'hC1, "svc hi R7");
        do_req(0, 18, 8'h33, "svc lo R7");
        do_req(0, 9, 8'd230, "pwm edge R8");
        do_req(0, 9, 8'd231, "pwm over R8");
        do_req(1, 8, 8'd9, "mfg other R9");
        do_req(1, 8, 8'd8, "mfg restore R9");
        sweep("R9");

        for (int n = 0; n < 3000; n++) begin
            int i = idxs[$urandom_range(0, 22)];
            logic [7:0] d = ($urandom_range(0, 3) == 0) ? corners[$urandom_range(0, 9)]
                                                        : 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) d = (i == 17) ? 8'($urandom_range(8'hC0, 8'hE7)) : d;
            do_req(1'($urandom_range(0, 1)), i, d, "random");
            if (n % 100 == 99) sweep("R11");
        end
        sweep("R11");
        summary();
    end
endmodule